// File: doc/BRIEF.md
# 8/16-bit ALU with Per-Operation Flag Policy

This unit performs the data-path arithmetic and logic work of a small 8-bit processor that also has a few 16-bit register-pair operations. Each cycle it takes a 4-bit operation code, two operands that have already been fetched, a bit index and the current flag byte. It computes a result, a new flag byte and a write-enable. All three outputs are registered, so they appear one clock after the inputs.

The operations are 8-bit AND, 16-bit AND, compare, 8-bit and 16-bit increment and decrement, one's complement, carry complement, single-bit test and a 16-bit "boolean" normalisation. Each operation has its own rule for the flags. Some flags are recomputed, some are cleared, and the rest are copied from the incoming flag byte. The caller uses the write-enable to decide whether the result goes back into a register.

Top module: `alu_flag_unit`

## Requirements
- R1: While rst_n is low, res, flags_out and wr_en are all zero.
- R2: Flag byte layout: S is bit 7, Z is bit 6, LV is bit 5-free position 2 and C is bit 0. Bits 5, 4, 3 and 1 of flags_out are always zero.
- R3: Op 1 (8-bit AND) gives res = {8'h00, opa[7:0] & opb[7:0]}. Op 2 (16-bit AND) gives res = opa & opb. For both, S is the result's top bit and Z is set when the result is zero. LV is set when any of the result's top four bits is 1. C is cleared and wr_en is 1.
- R4: Op 3 (compare) evaluates opa[7:0] - opb[7:0]. S and Z come from the difference. LV is set when the operand signs differ and the difference's sign differs from opa[7]. C is set on borrow. wr_en is 0 and res is 0.
- R5: Op 4 (increment) and op 5 (decrement) act on opa[7:0] and write the zero-extended result. S and Z come from the result. LV is set for 0x7F to 0x80 on increment and for 0x80 to 0x7F on decrement. C keeps flags_in[0].
- R6: Op 6 and op 7 increment and decrement the whole 16-bit opa, wrapping modulo 2^16, and write it back. The flags keep their incoming values.
- R7: Op 8 writes {8'h00, ~opa[7:0]} and leaves the flags unchanged. Op 9 inverts only C, leaves the other flags unchanged, and has wr_en = 0 and res = 0.
- R8: Op 10 (bit test) sets Z when bit bit_sel of opa[7:0] is 0 and clears it otherwise. S, LV and C are unchanged, wr_en is 0 and res is 0.
- R9: Op 11 (boolean) writes 16'h0001 when opa is nonzero and 16'h0000 when it is zero. S is 0, Z is set for a zero operand, and LV and C are cleared. wr_en is 1.
- R10: Op 0 and the unassigned ops 12 to 15 pass the flags through unchanged and give wr_en = 0 and res = 0.
- R11: The outputs are registered: they show the result of the inputs sampled at the previous rising edge of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| opa | input | 16 | First operand (accumulator or register pair) |
| opb | input | 16 | Second operand |
| bit_sel | input | 3 | Bit index for the bit test |
| flags_in | input | 8 | Current flag byte |
| res | output | 16 | Registered result |
| flags_out | output | 8 | Registered new flag byte |
| wr_en | output | 1 | Registered write-enable for res |

## Verification
The bench builds the unit with the default DW = 8, which gives 16-bit pairs and a 3-bit bit index. At this width every signed boundary can be reached with directed vectors: the 0x7F and 0x80 crossings, the 0xFF and 0xFFFF wraps, and a 16-bit value whose only set bit is bit 15. All eight bit-test positions and all sixteen operation codes are also covered. After the directed vectors come pseudo-random operands over every code and every incoming flag byte. These exercise the copy-through of the flags that each operation must preserve.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            op,
  input  logic [2*DW-1:0]       opa,
  input  logic [2*DW-1:0]       opb,
  input  logic [$clog2(DW)-1:0] bit_sel,
  input  logic [7:0]            flags_in,
  output logic [2*DW-1:0]       res,
  output logic [7:0]            flags_out,
  output logic                  wr_en
);
  localparam int PW = 2 * DW;
  localparam logic [3:0] OP_AND8 = 4'd1, OP_AND16 = 4'd2, OP_CMP = 4'd3,
                         OP_INC8 = 4'd4, OP_DEC8 = 4'd5, OP_INC16 = 4'd6,
                         OP_DEC16 = 4'd7, OP_CPL = 4'd8, OP_CCF = 4'd9,
                         OP_BIT = 4'd10, OP_BOOL = 4'd11;
  localparam logic [7:0] KEEP = 8'hC5;

  logic [DW-1:0] a8, b8, and8, inc8, dec8;
  logic [DW:0]   diff;
  logic [PW-1:0] and16, bool16, r_nx;
  logic [7:0]    f_in, f_nx;
  logic          we_nx;

  assign a8     = opa[DW-1:0];
  assign b8     = opb[DW-1:0];
  assign and8   = a8 & b8;
  assign inc8   = a8 + 1'b1;
  assign dec8   = a8 - 1'b1;
  assign diff   = {1'b0, a8} - {1'b0, b8};
  assign and16  = opa & opb;
  assign bool16 = {{(PW-1){1'b0}}, |opa};
  assign f_in   = flags_in & KEEP;

  function automatic logic [7:0] sz8(input logic [DW-1:0] v, input logic lv, input logic c);
    return {v[DW-1], ~|v, 3'b000, lv, 1'b0, c};
  endfunction

  function automatic logic [7:0] sz16(input logic [PW-1:0] v, input logic lv, input logic c);
    return {v[PW-1], ~|v, 3'b000, lv, 1'b0, c};
  endfunction

  always_comb begin
    r_nx  = '0;
    f_nx  = f_in;
    we_nx = 1'b0;
    case (op)
      OP_AND8: begin
        r_nx  = {{DW{1'b0}}, and8};
        f_nx  = sz8(and8, |and8[DW-1:DW-4], 1'b0);
        we_nx = 1'b1;
      end
      OP_AND16: begin
        r_nx  = and16;
        f_nx  = sz16(and16, |and16[PW-1:PW-4], 1'b0);
        we_nx = 1'b1;
      end
      OP_CMP:
        f_nx = sz8(diff[DW-1:0],
                   (a8[DW-1] ^ b8[DW-1]) & (diff[DW-1] ^ a8[DW-1]), diff[DW]);
      OP_INC8: begin
        r_nx  = {{DW{1'b0}}, inc8};
        f_nx  = sz8(inc8, ~a8[DW-1] & inc8[DW-1], f_in[0]);
        we_nx = 1'b1;
      end
      OP_DEC8: begin
        r_nx  = {{DW{1'b0}}, dec8};
        f_nx  = sz8(dec8, a8[DW-1] & ~dec8[DW-1], f_in[0]);
        we_nx = 1'b1;
      end
      OP_INC16: begin
        r_nx  = opa + 1'b1;
        we_nx = 1'b1;
      end
      OP_DEC16: begin
        r_nx  = opa - 1'b1;
        we_nx = 1'b1;
      end
      OP_CPL: begin
        r_nx  = {{DW{1'b0}}, ~a8};
        we_nx = 1'b1;
      end
      OP_CCF:  f_nx[0] = ~f_in[0];
      OP_BIT:  f_nx[6] = ~a8[bit_sel];
      OP_BOOL: begin
        r_nx  = bool16;
        f_nx  = sz16(bool16, 1'b0, 1'b0);
        we_nx = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      flags_out <= '0;
      wr_en     <= 1'b0;
    end else begin
      res       <= r_nx;
      flags_out <= f_nx;
      wr_en     <= we_nx;
    end
  end
endmodule

module alu_flag_unit_chk #(
  parameter int DW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            op,
  input logic [2*DW-1:0]       opa,
  input logic [7:0]            flags_in,
  input logic [2*DW-1:0]       res,
  input logic [7:0]            flags_out,
  input logic                  wr_en
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (res == '0 && flags_out == 8'h00 && !wr_en));

  // R2
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n) (flags_out & 8'h3A) == 8'h00);

  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd4 || op == 4'd5) |=> flags_out[0] == $past(flags_in[0]));

  // R6
  pair_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd6 || op == 4'd7) |=> (wr_en && flags_out == ($past(flags_in) & 8'hC5)));

  // R4
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n) (op == 4'd3) |=> !wr_en);

  // R8
  bit_only_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd10) |=> (!wr_en && (flags_out & 8'h85) == ($past(flags_in) & 8'h85)));

  // R9
  bool_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd11) |=> (res == {{(2*DW-1){1'b0}}, |$past(opa)} && flags_out[2] == 1'b0 && flags_out[0] == 1'b0));

  // R10
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0 || op >= 4'd12) |=> (!wr_en && flags_out == ($past(flags_in) & 8'hC5)));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .flags_in(flags_in),
  .res(res), .flags_out(flags_out), .wr_en(wr_en)
);

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] opa = '0, opb = '0;
  logic [2:0]  bit_sel = '0;
  logic [7:0]  flags_in = '0;
  logic [15:0] res;
  logic [7:0]  flags_out;
  logic        wr_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu_flag_unit #(.DW(8)) u_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb), .bit_sel(bit_sel),
    .flags_in(flags_in), .res(res), .flags_out(flags_out), .wr_en(wr_en)
  );

  // behavioural reference: returns {we, flags, res}
  function automatic logic [24:0] model(int o, int a, int b, int k, int f);
    int r = 0, we = 0, s, z, lv, c, a8, b8;
    a8 = a % 256; b8 = b % 256;
    s = (f >> 7) & 1; z = (f >> 6) & 1; lv = (f >> 2) & 1; c = f & 1;
    case (o)
      1, 2: begin
        r = (o == 1) ? (a8 & b8) : (a & b);
        s = (o == 1) ? (r >= 128) : (r >= 32768);
        z = (r == 0);
        lv = (o == 1) ? (r >= 16) : (r >= 4096);
        c = 0; we = 1;
      end
      3: begin
        int sa, sb, d;
        sa = (a8 >= 128) ? a8 - 256 : a8;
        sb = (b8 >= 128) ? b8 - 256 : b8;
        d = (a8 - b8 + 256) % 256;
        s = (d >= 128); z = (d == 0);
        lv = (sa - sb > 127) || (sa - sb < -128);
        c = (a8 < b8);
      end
      4: begin r = (a8 + 1) % 256; s = (r >= 128); z = (r == 0); lv = (a8 == 127); we = 1; end
      5: begin r = (a8 + 255) % 256; s = (r >= 128); z = (r == 0); lv = (a8 == 128); we = 1; end
      6: begin r = (a + 1) % 65536; we = 1; end
      7: begin r = (a + 65535) % 65536; we = 1; end
      8: begin r = 255 - a8; we = 1; end
      9: c = 1 - c;
      10: z = ((a8 >> k) & 1) == 0;
      11: begin r = (a != 0) ? 1 : 0; s = 0; z = (r == 0); lv = 0; c = 0; we = 1; end
      default: ;
    endcase
    model[24]    = we[0];
    model[23:16] = {s[0], z[0], 3'b000, lv[0], 1'b0, c[0]};
    model[15:0]  = r[15:0];
  endfunction

  task automatic step(input int o, input int a, input int b, input int k, input int f, input string tag);
    logic [24:0] exp;
    @(negedge clk);
    op = o[3:0]; opa = a[15:0]; opb = b[15:0]; bit_sel = k[2:0]; flags_in = f[7:0];
    exp = model(o, a, b, k, f);
    @(posedge clk); #1;
    n_chk++;
    if ({wr_en, flags_out, res} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h: got we=%b f=%h r=%h, expected we=%b f=%h r=%h",
               tag, o, a, b, wr_en, flags_out, res, exp[24], exp[23:16], exp[15:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with activity on inputs
    op = 4'd2; opa = 16'hFFFF; opb = 16'hFFFF; flags_in = 8'hFF;
    repeat (3) @(posedge clk);
    #1 n_chk++;
    if (res !== 16'h0 || flags_out !== 8'h00 || wr_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got r=%h f=%h we=%b, expected 0 0 0", res, flags_out, wr_en);
    end
    @(negedge clk) rst_n = 1'b1;

    step(1, 16'h12F0, 16'h34CC, 0, 8'h01, "R3 and8 lv");
    step(1, 16'h000F, 16'h0003, 0, 8'hFF, "R3 and8 low nibble");
    step(1, 16'h00AA, 16'h0055, 0, 8'h00, "R3 and8 zero");
    step(2, 16'h8000, 16'hFFFF, 0, 8'h01, "R3 and16 sign");
    step(2, 16'h0FFF, 16'h0F0F, 0, 8'h01, "R3 and16 no lv");
    step(3, 16'h0042, 16'h0042, 0, 8'h00, "R4 cmp equal");
    step(3, 16'h0010, 16'h0020, 0, 8'h00, "R4 cmp borrow");
    step(3, 16'h0080, 16'h0001, 0, 8'h00, "R4 cmp overflow");
    step(3, 16'h007F, 16'h00FF, 0, 8'h00, "R4 cmp overflow up");
    step(4, 16'h007F, 0, 0, 8'h01, "R5 inc 7F");
    step(4, 16'h00FF, 0, 0, 8'h00, "R5 inc FF");
    step(5, 16'h0080, 0, 0, 8'h01, "R5 dec 80");
    step(5, 16'h0000, 0, 0, 8'h00, "R5 dec 00");
    step(5, 16'h0001, 0, 0, 8'hFF, "R5 dec to zero");
    step(6, 16'hFFFF, 0, 0, 8'hC5, "R6 inc16 wrap");
    step(7, 16'h0000, 0, 0, 8'h44, "R6 dec16 wrap");
    step(7, 16'h8000, 0, 0, 8'hFF, "R2 R6 dec16 unused bits");
    step(8, 16'hAB5A, 0, 0, 8'h85, "R7 cpl");
    step(9, 16'h1234, 0, 0, 8'hC4, "R7 ccf set");
    step(9, 16'h1234, 0, 0, 8'h45, "R7 ccf clear");
    for (int k = 0; k < 8; k++) begin
      step(10, 16'h00A5, 0, k, 8'h85, "R8 bit test");
      step(10, 16'h005A, 0, k, 8'h40, "R8 bit test inv");
    end
    step(11, 16'h0000, 0, 0, 8'hBF, "R9 bool zero");
    step(11, 16'h8000, 0, 0, 8'h85, "R9 bool top");
    step(11, 16'h0001, 0, 0, 8'h00, "R9 bool one");
    for (int o = 12; o < 16; o++) step(o, 16'hFFFF, 16'hFFFF, 0, 8'hC5, "R10 unassigned");
    step(0, 16'h1234, 0, 0, 8'hFF, "R10 nop");
    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 255)), "R11 random");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule